// File: doc/BRIEF.md
# Bit-Addressed Conversion Register Pair

This block holds the working state for a successive-approximation conversion done under program control. Two nibble registers, a high one and a low one, together form an 8-bit result. A 3-bit select counter points at one bit of that result. Its top bit picks the nibble and its lower bits pick the position inside it.

An instruction decoder drives one strobe per operation:

- move the accumulator value into either nibble;
- swap the accumulator value with either nibble;
- load the counter with its top value, or step it down;
- set or clear the bit the counter points at.

Software starts with the counter at 7. It sets the addressed bit and lets an outside comparator decide whether to clear it again. It then steps the counter down. When the counter wraps back to 7, the step raises a skip request so that the conversion loop ends. The comparator and the DAC lie outside the block.

The accumulator value enters on `acc_i` and comes back on `acc_o`. During a swap, `acc_o` carries the old nibble. At any other time it passes `acc_i` through unchanged.

Top module: `sar_bit_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 7, both nibbles become 0, and `skip_o` is 0 in the following cycle.
- R2: An effective load strobe (`sel_load_i`) sets the counter to 7 at the next edge and leaves both nibbles unchanged.
- R3: An effective decrement strobe (`sel_dec_i`) sets the counter to (C-1) mod 8 at the next edge. `skip_o` is high combinationally in that same cycle exactly when C is 0, so that the result wraps to 7, and is low in every other cycle.
- R4: An effective set strobe (`bit_set_i`) sets one bit at the next edge and changes no other bit. When C[2]=1 the bit is in H (`res_o[7:4]`), otherwise in L (`res_o[3:0]`). Its position within the nibble is C[1:0]. The counter does not change.
- R5: An effective clear strobe (`bit_clr_i`) clears that same addressed bit at the next edge and changes no other bit or the counter.
- R6: A transfer strobe (`xfer_lo_i` for L, `xfer_hi_i` for H) copies `acc_i` into that nibble at the next edge. `acc_o` equals `acc_i` in that cycle, and the other nibble and the counter keep their values.
- R7: A swap strobe (`xch_lo_i` for L, `xch_hi_i` for H) makes `acc_o` show the nibble's old value in that cycle and loads `acc_i` into the nibble at the next edge, all in one step.
- R8: Exactly one operation is performed per cycle. When strobes coincide, the winner is taken in this order: `xch_lo_i`, `xch_hi_i`, `xfer_lo_i`, `xfer_hi_i`, `bit_set_i`, `bit_clr_i`, `sel_load_i`, `sel_dec_i`.
- R9: With no strobe high, the nibbles and the counter hold their values and `acc_o` equals `acc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 4 | Accumulator value from the datapath |
| xch_lo_i | input | 1 | Swap accumulator with L |
| xch_hi_i | input | 1 | Swap accumulator with H |
| xfer_lo_i | input | 1 | Copy accumulator into L |
| xfer_hi_i | input | 1 | Copy accumulator into H |
| bit_set_i | input | 1 | Set the bit addressed by the counter |
| bit_clr_i | input | 1 | Clear the bit addressed by the counter |
| sel_load_i | input | 1 | Load 7 into the counter |
| sel_dec_i | input | 1 | Step the counter down with a wrap test |
| acc_o | output | 4 | Accumulator value returned (old nibble on swap) |
| res_o | output | 8 | Result {H, L} |
| sel_o | output | 3 | Current bit-select counter |
| skip_o | output | 1 | Skip request from a wrapping decrement |

## Verification
`acc_o` and `skip_o` are combinational in the cycle of the strobe. The bench therefore samples them one time unit after it drives the inputs on the falling edge, before the rising edge that performs the operation. `res_o` and `sel_o` change at that rising edge, so they are checked one time unit after it, against a model that the bench advances from the values it held before the edge. The sweeps cover:

- every strobe combination with a fixed accumulator value, which exercises priority;
- every accumulator value for the transfers and the swaps;
- every counter value for set and clear;
- a full decrement lap, including the wrap.

// File: rtl/sar_bit_regs_pkg.sv
package sar_bit_regs_pkg;

    // Operation chosen for the current cycle, in priority order after NONE.
    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_XCH_LO = 4'd1,
        OP_XCH_HI = 4'd2,
        OP_XFER_LO = 4'd3,
        OP_XFER_HI = 4'd4,
        OP_BIT_SET = 4'd5,
        OP_BIT_CLR = 4'd6,
        OP_SEL_LOAD = 4'd7,
        OP_SEL_DEC = 4'd8
    } op_e;

    // Raw strobes from the decoder.
    typedef struct packed {
        logic xch_lo;
        logic xch_hi;
        logic xfer_lo;
        logic xfer_hi;
        logic bit_set;
        logic bit_clr;
        logic sel_load;
        logic sel_dec;
    } strobe_t;

    // Fixed priority: swaps, then transfers, then bit ops, then counter ops.
    function automatic op_e pick_op(input strobe_t s);
        op_e r;
        if (s.xch_lo) r = OP_XCH_LO;
        else if (s.xch_hi) r = OP_XCH_HI;
        else if (s.xfer_lo) r = OP_XFER_LO;
        else if (s.xfer_hi) r = OP_XFER_HI;
        else if (s.bit_set) r = OP_BIT_SET;
        else if (s.bit_clr) r = OP_BIT_CLR;
        else if (s.sel_load) r = OP_SEL_LOAD;
        else if (s.sel_dec) r = OP_SEL_DEC;
        else r = OP_NONE;
        return r;
    endfunction

    function automatic logic is_bit_op(input op_e op);
        return (op == OP_BIT_SET) || (op == OP_BIT_CLR);
    endfunction

endpackage

// File: rtl/sar_op_arbiter.sv
module sar_op_arbiter
    import sar_bit_regs_pkg::*;
(
    input strobe_t strobes_i,
    output op_e op_o
);

    always_comb begin
        op_o = pick_op(strobes_i);
    end

endmodule

// File: rtl/sar_sel_counter.sv
module sar_sel_counter
    import sar_bit_regs_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input logic clk,
    input logic rst,
    input op_e op_i,
    output logic [SEL_W-1:0] sel_o,
    output logic skip_o
);

    localparam logic [SEL_W-1:0] SEL_TOP = '1;
    localparam logic [SEL_W-1:0] SEL_ONE = SEL_W'(1);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        unique case (op_i)
            OP_SEL_LOAD: sel_d = SEL_TOP;
            OP_SEL_DEC: sel_d = sel_q - SEL_ONE;
            default: sel_d = sel_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SEL_TOP;
        else sel_q <= sel_d;
    end

    // Wrap to the top value happens exactly when stepping down from zero.
    assign skip_o = (op_i == OP_SEL_DEC) && (sel_q == '0);
    assign sel_o = sel_q;

endmodule

// File: rtl/sar_nibble_pair.sv
module sar_nibble_pair
    import sar_bit_regs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic clk,
    input logic rst,
    input op_e op_i,
    input logic [NIB_W-1:0] acc_i,
    input logic [$clog2(NIB_W):0] sel_i,
    output logic [NIB_W-1:0] acc_o,
    output logic [NIB_W-1:0] hi_o,
    output logic [NIB_W-1:0] lo_o
);

    localparam int POS_W = $clog2(NIB_W);
    localparam int SEL_W = POS_W + 1;

    logic [NIB_W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [NIB_W-1:0] pos_mask;
    logic [NIB_W-1:0] bit_hi, bit_lo;
    logic pick_hi;

    assign pick_hi = sel_i[SEL_W-1];

    // One-hot mask of the addressed position inside a nibble.
    for (genvar i = 0; i < NIB_W; i++) begin : g_pos
        assign pos_mask[i] = (sel_i[POS_W-1:0] == POS_W'(i));
    end

    // Per-bit next value for the bit operations.
    for (genvar i = 0; i < NIB_W; i++) begin : g_bits
        always_comb begin
            bit_hi[i] = hi_q[i];
            bit_lo[i] = lo_q[i];
            if (is_bit_op(op_i) && pos_mask[i]) begin
                if (pick_hi) bit_hi[i] = (op_i == OP_BIT_SET);
                else bit_lo[i] = (op_i == OP_BIT_SET);
            end
        end
    end

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        acc_o = acc_i;
        unique case (op_i)
            OP_XCH_LO: begin
                lo_d = acc_i;
                acc_o = lo_q;
            end
            OP_XCH_HI: begin
                hi_d = acc_i;
                acc_o = hi_q;
            end
            OP_XFER_LO: lo_d = acc_i;
            OP_XFER_HI: hi_d = acc_i;
            OP_BIT_SET, OP_BIT_CLR: begin
                hi_d = bit_hi;
                lo_d = bit_lo;
            end
            default: begin
                hi_d = hi_q;
                lo_d = lo_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

endmodule

// File: rtl/sar_bit_regs.sv
module sar_bit_regs
    import sar_bit_regs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic clk,
    input logic rst,
    input logic [NIB_W-1:0] acc_i,
    input logic xch_lo_i,
    input logic xch_hi_i,
    input logic xfer_lo_i,
    input logic xfer_hi_i,
    input logic bit_set_i,
    input logic bit_clr_i,
    input logic sel_load_i,
    input logic sel_dec_i,
    output logic [NIB_W-1:0] acc_o,
    output logic [2*NIB_W-1:0] res_o,
    output logic [$clog2(NIB_W):0] sel_o,
    output logic skip_o
);

    localparam int SEL_W = $clog2(NIB_W) + 1;

    strobe_t strobes;
    op_e op;
    logic [NIB_W-1:0] hi, lo;
    logic [SEL_W-1:0] sel;

    always_comb begin
        strobes.xch_lo = xch_lo_i;
        strobes.xch_hi = xch_hi_i;
        strobes.xfer_lo = xfer_lo_i;
        strobes.xfer_hi = xfer_hi_i;
        strobes.bit_set = bit_set_i;
        strobes.bit_clr = bit_clr_i;
        strobes.sel_load = sel_load_i;
        strobes.sel_dec = sel_dec_i;
    end

    sar_op_arbiter u_arb (
        .strobes_i(strobes),
        .op_o(op)
    );

    sar_sel_counter #(.SEL_W(SEL_W)) u_cnt (
        .clk(clk),
        .rst(rst),
        .op_i(op),
        .sel_o(sel),
        .skip_o(skip_o)
    );

    sar_nibble_pair #(.NIB_W(NIB_W)) u_nib (
        .clk(clk),
        .rst(rst),
        .op_i(op),
        .acc_i(acc_i),
        .sel_i(sel),
        .acc_o(acc_o),
        .hi_o(hi),
        .lo_o(lo)
    );

    assign res_o = {hi, lo};
    assign sel_o = sel;

endmodule

// File: rtl/sar_bit_regs_chk.sv
module sar_bit_regs_chk #(
    parameter int NIB_W = 4
) (
    input logic clk,
    input logic rst,
    input logic [NIB_W-1:0] acc_i,
    input logic xch_lo_i,
    input logic xch_hi_i,
    input logic xfer_lo_i,
    input logic xfer_hi_i,
    input logic bit_set_i,
    input logic bit_clr_i,
    input logic sel_load_i,
    input logic sel_dec_i,
    input logic [NIB_W-1:0] acc_o,
    input logic [2*NIB_W-1:0] res_o,
    input logic [$clog2(NIB_W):0] sel_o,
    input logic skip_o
);

    localparam int SEL_W = $clog2(NIB_W) + 1;

    logic [7:0] all_s;
    logic single;

    assign all_s = {xch_lo_i, xch_hi_i, xfer_lo_i, xfer_hi_i, bit_set_i, bit_clr_i, sel_load_i, sel_dec_i};
    assign single = ($countones(all_s) == 1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (res_o == '0) && (sel_o == '1) && !skip_o);

    assert_load_top_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_load_i && single) |=> (sel_o == '1) && $stable(res_o));

    assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_dec_i && single) |=> (sel_o == SEL_W'($past(sel_o) - 1'b1)));

    assert_skip_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        skip_o |=> (sel_o == '1));

    assert_skip_needs_dec_R3: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> (sel_dec_i && (sel_o == '0)));

    assert_set_keeps_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_set_i && single) |=> $stable(sel_o) && ($countones(res_o) >= $countones($past(res_o))));

    assert_clr_keeps_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_clr_i && single) |=> $stable(sel_o) && ($countones(res_o) <= $countones($past(res_o))));

    assert_xfer_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_lo_i && single) |=> (res_o[NIB_W-1:0] == $past(acc_i)) && (res_o[2*NIB_W-1:NIB_W] == $past(res_o[2*NIB_W-1:NIB_W])));

    assert_xfer_acc_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_hi_i && single) |-> (acc_o == acc_i));

    assert_xch_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (xch_lo_i) |=> (res_o[NIB_W-1:0] == $past(acc_i)) && ($past(acc_o) == $past(res_o[NIB_W-1:0])));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (all_s == '0) |=> $stable(res_o) && $stable(sel_o));

endmodule

bind sar_bit_regs sar_bit_regs_chk #(.NIB_W(NIB_W)) u_chk (
    .clk(clk),
    .rst(rst),
    .acc_i(acc_i),
    .xch_lo_i(xch_lo_i),
    .xch_hi_i(xch_hi_i),
    .xfer_lo_i(xfer_lo_i),
    .xfer_hi_i(xfer_hi_i),
    .bit_set_i(bit_set_i),
    .bit_clr_i(bit_clr_i),
    .sel_load_i(sel_load_i),
    .sel_dec_i(sel_dec_i),
    .acc_o(acc_o),
    .res_o(res_o),
    .sel_o(sel_o),
    .skip_o(skip_o)
);

// File: tb/sar_bit_regs_tb.sv
`timescale 1ns/1ps
module sar_bit_regs_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] acc_i = '0;
    logic [7:0] ops = '0; // [7]xch_lo [6]xch_hi [5]xfer_lo [4]xfer_hi [3]set [2]clr [1]load [0]dec
    logic [3:0] acc_o;
    logic [7:0] res_o;
    logic [2:0] sel_o;
    logic skip_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // Bench model state.
    logic [3:0] mh = '0, ml = '0;
    logic [2:0] mc = 3'd7;

    always #5 clk = ~clk;

    sar_bit_regs u_dut (
        .clk(clk), .rst(rst), .acc_i(acc_i),
        .xch_lo_i(ops[7]), .xch_hi_i(ops[6]), .xfer_lo_i(ops[5]), .xfer_hi_i(ops[4]),
        .bit_set_i(ops[3]), .bit_clr_i(ops[2]), .sel_load_i(ops[1]), .sel_dec_i(ops[0]),
        .acc_o(acc_o), .res_o(res_o), .sel_o(sel_o), .skip_o(skip_o)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, got, exp);
        end
    endtask

    // Drive one cycle of strobes; check combinational outputs before the edge
    // and registered outputs after it.
    task automatic apply(input logic [7:0] o, input logic [3:0] a, input string tag);
        int win;
        logic [3:0] e_acc, nh, nl;
        logic [2:0] nc;
        logic e_skip;
        logic [3:0] m;
        @(negedge clk);
        ops = o;
        acc_i = a;
        win = 8;
        for (int k = 7; k >= 0; k--) begin
            if (o[k] && win == 8) win = 7 - k;
        end
        e_acc = a; e_skip = 1'b0; nh = mh; nl = ml; nc = mc;
        m = 4'b1 << mc[1:0];
        case (win)
            0: begin e_acc = ml; nl = a; end
            1: begin e_acc = mh; nh = a; end
            2: nl = a;
            3: nh = a;
            4: if (mc[2]) nh = mh | m; else nl = ml | m;
            5: if (mc[2]) nh = mh & ~m; else nl = ml & ~m;
            6: nc = 3'd7;
            7: begin nc = mc - 3'd1; e_skip = (mc == 3'd0); end
            default: ;
        endcase
        #1;
        check({4'h0, acc_o}, {4'h0, e_acc}, {tag, " acc_o"});
        check({7'h0, skip_o}, {7'h0, e_skip}, {tag, " skip_o"});
        @(posedge clk);
        #1;
        mh = nh; ml = nl; mc = nc;
        check(res_o, {mh, ml}, {tag, " res_o"});
        check({5'h0, sel_o}, {5'h0, mc}, {tag, " sel_o"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ops = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mh = '0; ml = '0; mc = 3'd7;
        check(res_o, 8'h00, "R1 res_o after reset");
        check({5'h0, sel_o}, 8'h07, "R1 sel_o after reset");
        check({7'h0, skip_o}, 8'h00, "R1 skip_o after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();

        // R9 idle holds state.
        apply(8'h00, 4'h9, "R9 idle");

        // R6 transfers for every accumulator value.
        for (int a = 0; a < 16; a++) begin
            apply(8'h20, 4'(a), "R6 xfer_lo");
            apply(8'h10, 4'(15 - a), "R6 xfer_hi");
        end

        // R7 swaps for every accumulator value.
        for (int a = 0; a < 16; a++) begin
            apply(8'h80, 4'(a), "R7 xch_lo");
            apply(8'h40, 4'(a ^ 5), "R7 xch_hi");
        end

        // R2 load; R4/R5 set and clear at every counter value; R3 full lap.
        apply(8'h02, 4'h0, "R2 load");
        apply(8'h20, 4'h0, "R6 clear lo");
        apply(8'h10, 4'h0, "R6 clear hi");
        for (int i = 0; i < 8; i++) begin
            apply(8'h08, 4'h3, "R4 set bit");
            apply(8'h00, 4'h3, "R9 idle after set");
            apply(8'h04, 4'h3, "R5 clear bit");
            apply(8'h08, 4'h3, "R4 set bit again");
            apply(8'h01, 4'h3, "R3 decrement");
        end
        for (int i = 0; i < 8; i++) begin
            apply(8'h04, 4'h0, "R5 clear walk");
            apply(8'h01, 4'h0, "R3 decrement walk");
        end
        apply(8'h01, 4'h0, "R3 decrement");
        apply(8'h02, 4'h0, "R2 reload");

        // R8 every strobe combination.
        for (int v = 0; v < 256; v++) begin
            apply(8'(v), 4'(v * 7), "R8 priority sweep");
        end

        // R1 reset again from a disturbed state.
        apply(8'h01, 4'h0, "R3 decrement before reset");
        apply(8'h40, 4'hF, "R7 xch_hi before reset");
        do_reset();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule